// File: doc/BRIEF.md
# Tile Pipeline Instruction Sequencer

This control unit runs a short program held in an external program memory and turns each instruction into a timed command for a matrix datapath. Each 32-bit word carries a 4-bit opcode, an 8-bit immediate and a 16-bit operand address. After the program is loaded and `start` is raised, the unit reads words from address 0 onward. It reads each word in a FETCH cycle and decodes it in a DECODE cycle. It then holds the execution state for that opcode for a fixed number of cycles, set from the tile size N. The states are weight load, activation load, compute, store, activation function and normalization. In the first cycle of that state it pulses one bit of a one-hot command bus and presents the operand address, the immediate and the opcode beside it.

The datapath answers every command with a one-cycle `op_done` pulse, which may come at any later time. The unit counts the operations that have not yet answered. A SYNC instruction parks the unit in a drain state until that count is zero. When the count reaches a set limit, further issue stalls. A LOOP instruction repeats a section of the program a number of times given by its immediate. HALT raises `done`, which stays high until `start` is released, and the unit then returns to idle.

Top module: `tile_seq`

## Requirements
- R1: After reset, `done` is low, `cmd` is all zero and `imem_addr` is 0.
- R2: A rising `start` in idle begins execution at program address 0. HALT (opcode 0xF) makes `done` go high three cycles after the program-memory read that returned it was requested. `done` stays high and no command is issued while `start` stays high. One cycle after `start` falls, `done` is low.
- R3: The program memory has one cycle of read latency. Each instruction spends one FETCH cycle and one DECODE cycle. The word layout is opcode in [31:28], reserved in [27:24], immediate in [23:16] and address in [15:0]. NOP (0x0), and any word whose reserved nibble is non-zero, costs exactly two cycles and issues nothing.
- R4: The command bit is pulsed in the first cycle of the execution state, and the state is held for a fixed budget. LOAD_W (0x1) pulses `cmd[0]` and LOAD_A (0x2) pulses `cmd[1]`, each for N cycles. MATMUL (0x3) pulses `cmd[2]` for 2N-1 cycles. STORE (0x4) pulses `cmd[3]` for N cycles.
- R5: Opcodes 0x5, 0x6, 0x7, 0x8, 0x9, 0xB and 0xC pulse `cmd[4]` and occupy N cycles. `cmd_func` carries the opcode and `cmd_imm` carries bits [23:16].
- R6: LAYERNORM (0xA) pulses `cmd[5]` and occupies 2N cycles.
- R7: `cmd` is one-hot or zero, and each pulse lasts one cycle. `cmd_addr` equals bits [15:0] of the issuing instruction while the pulse is high.
- R8: SYNC (0xD) enters a drain state. It leaves that state one cycle after the outstanding count reaches zero, so the next command is issued at least three cycles after the SYNC is decoded.
- R9: LOOP (0xE) with immediate K > 0 branches to address bits [PC_W-1:0] K times, so the body runs K+1 times. After that the LOOP falls through. With K = 0 it falls through at once.
- R10: At most OUT_DEPTH commands are outstanding. A command decoded while the limit is reached waits in DECODE and issues in the cycle after a completion is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request; must be released after done |
| imem_addr | output | PC_W | Program memory read address |
| imem_rdata | input | 32 | Program word, one cycle after the address |
| op_done | input | 1 | One-cycle completion pulse from the datapath |
| cmd | output | 6 | One-hot command strobe |
| cmd_addr | output | 16 | Operand address of the issued command |
| cmd_imm | output | 8 | Immediate of the issued command |
| cmd_func | output | 4 | Opcode of the issued command |
| done | output | 1 | Program has halted |

## Verification
The hardest situation to reach is the issue stall at the outstanding limit, together with the exact cycle at which it releases. Reaching it needs completions that arrive much later than the execution budgets. The bench's datapath model therefore acknowledges each command after a programmable delay of 150 cycles, and a program of six weight loads fills the counter. The check then requires the fifth and sixth commands to issue in the cycle after the first and second completions. The second release coincides with the DECODE entry, so a one-cycle slip in the counter or in the stall logic shows up.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'h0, OP_LDW  = 4'h1, OP_LDA  = 4'h2, OP_MMUL = 4'h3,
    OP_STO  = 4'h4, OP_RELU = 4'h5, OP_GELU = 4'h6, OP_SILU = 4'h7,
    OP_SMAX = 4'h8, OP_ADD  = 4'h9, OP_LNRM = 4'hA, OP_XPOS = 4'hB,
    OP_SCAL = 4'hC, OP_SYNC = 4'hD, OP_LOOP = 4'hE, OP_HALT = 4'hF
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_WLOAD, S_ALOAD, S_COMPUTE,
    S_DRAIN, S_STORE, S_ACTIV, S_NORM, S_HALT
  } st_e;

  localparam int CMD_N = 6;
  localparam int C_WLD = 0;
  localparam int C_ALD = 1;
  localparam int C_MUL = 2;
  localparam int C_STO = 3;
  localparam int C_ACT = 4;
  localparam int C_NRM = 5;
endpackage

// File: rtl/tseq_decode.sv
module tseq_decode
  import tseq_pkg::*;
#(
  parameter int N     = 8,
  parameter int BUD_W = 5
) (
  input  logic [31:0]      word,
  output op_e              op,
  output logic [7:0]       imm,
  output logic [15:0]      addr,
  output st_e              nxt,
  output logic [BUD_W-1:0] budget,
  output logic [CMD_N-1:0] cmd_v
);
  localparam logic [BUD_W-1:0] B_TILE = BUD_W'(N);
  localparam logic [BUD_W-1:0] B_FILL = BUD_W'(2*N-1);
  localparam logic [BUD_W-1:0] B_NORM = BUD_W'(2*N);

  always_comb begin
    // non-zero reserved nibble demotes the word to a no-op
    op     = (word[27:24] != 4'h0) ? OP_NOP : op_e'(word[31:28]);
    imm    = word[23:16];
    addr   = word[15:0];
    nxt    = S_FETCH;
    budget = BUD_W'(1);
    cmd_v  = '0;
    case (op)
      OP_LDW:  begin nxt = S_WLOAD;   budget = B_TILE; cmd_v[C_WLD] = 1'b1; end
      OP_LDA:  begin nxt = S_ALOAD;   budget = B_TILE; cmd_v[C_ALD] = 1'b1; end
      OP_MMUL: begin nxt = S_COMPUTE; budget = B_FILL; cmd_v[C_MUL] = 1'b1; end
      OP_STO:  begin nxt = S_STORE;   budget = B_TILE; cmd_v[C_STO] = 1'b1; end
      OP_RELU, OP_GELU, OP_SILU, OP_SMAX, OP_ADD, OP_XPOS, OP_SCAL:
               begin nxt = S_ACTIV;   budget = B_TILE; cmd_v[C_ACT] = 1'b1; end
      OP_LNRM: begin nxt = S_NORM;    budget = B_NORM; cmd_v[C_NRM] = 1'b1; end
      OP_SYNC: nxt = S_DRAIN;
      OP_HALT: nxt = S_HALT;
      default: nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/tseq_loop.sv
module tseq_loop #(
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hit,
  input  logic [IMM_W-1:0] imm,
  output logic             take
);
  logic             active;
  logic [IMM_W-1:0] left;

  assign take = active ? (left != '0) : (imm != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active <= 1'b0;
      left   <= '0;
    end else if (hit) begin
      if (active) begin
        if (left == '0) active <= 1'b0;
        else            left   <= left - IMM_W'(1);
      end else if (imm != '0) begin
        active <= 1'b1;
        left   <= imm - IMM_W'(1);
      end
    end
  end
endmodule

// File: rtl/tseq_track.sv
module tseq_track #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             empty
);
  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CNT_W'(inc) - CNT_W'(dec && (inc || !empty));
  end
endmodule

// File: rtl/tile_seq.sv
module tile_seq
  import tseq_pkg::*;
#(
  parameter int PC_W      = 6,
  parameter int N         = 8,
  parameter int OUT_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [31:0]       imem_rdata,
  input  logic              op_done,
  output logic [CMD_N-1:0]  cmd,
  output logic [15:0]       cmd_addr,
  output logic [7:0]        cmd_imm,
  output logic [3:0]        cmd_func,
  output logic              done
);
  localparam int BUD_W = $clog2(2*N + 1);
  localparam int CNT_W = $clog2(OUT_DEPTH + 1);

  st_e              state;
  logic [PC_W-1:0]  pc;
  logic [BUD_W-1:0] left;

  op_e              op;
  logic [7:0]       imm;
  logic [15:0]      addr;
  st_e              nxt;
  logic [BUD_W-1:0] budget;
  logic [CMD_N-1:0] cmd_v;

  logic             trk_full, trk_empty;
  logic [CNT_W-1:0] trk_cnt;
  logic             in_dec, advance, issue, loop_hit, loop_take, run_go;

  tseq_decode #(.N(N), .BUD_W(BUD_W)) u_dec (
    .word(imem_rdata), .op(op), .imm(imm), .addr(addr),
    .nxt(nxt), .budget(budget), .cmd_v(cmd_v)
  );

  assign in_dec   = (state == S_DECODE);
  assign advance  = (cmd_v == '0) || !trk_full;
  assign issue    = in_dec && (cmd_v != '0) && !trk_full;
  assign loop_hit = in_dec && (op == OP_LOOP);
  assign run_go   = (state == S_IDLE) && start;

  tseq_loop #(.IMM_W(8)) u_loop (
    .clk(clk), .rst(rst), .clr(run_go), .hit(loop_hit),
    .imm(imm), .take(loop_take)
  );

  tseq_track #(.DEPTH(OUT_DEPTH), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst(rst), .inc(issue), .dec(op_done),
    .cnt(trk_cnt), .full(trk_full), .empty(trk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      pc    <= '0;
      left  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pc    <= '0;
          state <= S_FETCH;
        end
        S_FETCH: state <= S_DECODE;
        S_DECODE: if (advance) begin
          state <= nxt;
          left  <= budget - BUD_W'(1);
          pc    <= (loop_hit && loop_take) ? addr[PC_W-1:0] : pc + PC_W'(1);
        end
        S_DRAIN: if (trk_empty) state <= S_FETCH;
        S_HALT:  if (!start) state <= S_IDLE;
        default: begin
          if (left == '0) state <= S_FETCH;
          else            left  <= left - BUD_W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd      <= '0;
      cmd_addr <= '0;
      cmd_imm  <= '0;
      cmd_func <= '0;
    end else begin
      cmd <= issue ? cmd_v : '0;
      if (issue) begin
        cmd_addr <= addr;
        cmd_imm  <= imm;
        cmd_func <= op;
      end
    end
  end

  assign imem_addr = pc;
  assign done      = (state == S_HALT);
endmodule

// File: rtl/tile_seq_chk.sv
module tile_seq_chk #(
  parameter int CMD_W     = 6,
  parameter int OUT_DEPTH = 4,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic [CMD_W-1:0] cmd,
  input logic [CNT_W-1:0] cnt
);
  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd)); // R7
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cmd != '0) |=> (cmd == '0)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> done); // R2
  AST_DONE_DROP: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (cmd == '0)); // R2
  AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(OUT_DEPTH)); // R10
endmodule

bind tile_seq tile_seq_chk #(.CMD_W(tseq_pkg::CMD_N), .OUT_DEPTH(OUT_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done), .cmd(cmd), .cnt(trk_cnt)
);

// File: tb/tile_seq_bench.sv
`timescale 1ns/1ps
module tile_seq_bench;
  localparam int PC_W = 6;
  localparam int N    = 8;
  localparam int DEP  = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [PC_W-1:0] imem_addr;
  logic [31:0]     imem_rdata = '0;
  logic            op_done = 1'b0;
  logic [5:0]      cmd;
  logic [15:0]     cmd_addr;
  logic [7:0]      cmd_imm;
  logic [3:0]      cmd_func;
  logic            done;

  tile_seq #(.PC_W(PC_W), .N(N), .OUT_DEPTH(DEP)) u_tile_seq (
    .clk(clk), .rst(rst), .start(start), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .op_done(op_done), .cmd(cmd),
    .cmd_addr(cmd_addr), .cmd_imm(cmd_imm), .cmd_func(cmd_func), .done(done)
  );

  always #5 clk = ~clk;

  logic [31:0] prog [64];
  always @(posedge clk) imem_rdata <= prog[imem_addr];

  int ntot = 0, nbad = 0, cyc = 0, t0 = 0;
  int ack_dly = 4, infl = 0, maxinfl = 0, nlog = 0;
  bit finished = 0;
  logic [255:0] pend = '0;
  int lg_t [16]; int lg_c [16]; int lg_a [16]; int lg_i [16]; int lg_f [16];

  initial forever begin @(posedge clk); cyc++; end

  // datapath model: logs commands, acknowledges after ack_dly cycles
  initial forever begin
    @(negedge clk);
    if (rst) begin
      pend = '0; op_done = 1'b0; infl = 0; maxinfl = 0;
    end else begin
      if (op_done) infl--;
      if (cmd != '0) begin
        infl++;
        if (nlog < 16) begin
          lg_t[nlog] = cyc - t0; lg_c[nlog] = int'(cmd); lg_a[nlog] = int'(cmd_addr);
          lg_i[nlog] = int'(cmd_imm); lg_f[nlog] = int'(cmd_func);
        end
        nlog++;
      end
      if (infl > maxinfl) maxinfl = infl;
      pend = pend >> 1;
      if (cmd != '0) pend[ack_dly] = 1'b1;
      op_done = pend[0];
    end
  end

  function automatic logic [31:0] ins(logic [3:0] op, logic [7:0] imm, logic [15:0] a);
    return {op, 4'h0, imm, a};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(int dly);
    @(negedge clk);
    rst = 1'b1; start = 1'b0; ack_dly = dly;
    for (int i = 0; i < 64; i++) prog[i] = ins(4'hF, 8'h0, 16'h0);
    repeat (3) @(negedge clk);
    rst = 1'b0; nlog = 0;
  endtask

  task automatic run(output int td);
    @(negedge clk);
    start = 1'b1; t0 = cyc; td = -1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (done) begin td = cyc - t0; break; end
    end
    repeat (2) @(negedge clk);
    repeat (ack_dly + 4) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(4);
    chk("R1", "done", int'(done), 0);
    chk("R1", "cmd", int'(cmd), 0);
    chk("R1", "imem_addr", int'(imem_addr), 0);
  endtask

  task automatic t_halt();
    do_reset(4);
    @(negedge clk); start = 1'b1; t0 = cyc;
    repeat (3) @(negedge clk);
    chk("R2", "done time", int'(done), 1);
    repeat (5) @(negedge clk);
    chk("R2", "done held with start", int'(done), 1);
    chk("R2", "no command at halt", nlog, 0);
    start = 1'b0;
    @(negedge clk);
    chk("R2", "done after start low", int'(done), 0);
  endtask

  task automatic t_nop();
    int td;
    do_reset(4);
    prog[0] = ins(4'h0, 8'h0, 16'h0);
    prog[1] = {4'h1, 4'h3, 8'h0, 16'h5000};   // reserved bits set: no-op
    run(td);
    chk("R3", "halt time after two no-ops", td, 7);
    chk("R3", "no strobes", nlog, 0);
  endtask

  task automatic t_tile();
    int td;
    int e [4];
    do_reset(4);
    prog[0] = ins(4'h1, 8'h0, 16'h5000);
    prog[1] = ins(4'h2, 8'h0, 16'h0040);
    prog[2] = ins(4'h3, 8'h0, 16'h0000);
    prog[3] = ins(4'h4, 8'h0, 16'hB000);
    run(td);
    e[0] = 3; e[1] = e[0] + N + 2; e[2] = e[1] + N + 2; e[3] = e[2] + 2*N - 1 + 2;
    chk("R4", "strobe count", nlog, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R4", "strobe time", lg_t[i], e[i]);
      chk("R4", "strobe bit", lg_c[i], 1 << i);
    end
    chk("R7", "weight addr", lg_a[0], 'h5000);
    chk("R7", "act addr", lg_a[1], 'h0040);
    chk("R7", "store addr", lg_a[3], 'hB000);
    chk("R4", "halt time", td, e[3] + N + 2);
  endtask

  task automatic t_act();
    int td;
    do_reset(4);
    prog[0] = ins(4'h6, 8'd5, 16'h0100);
    prog[1] = ins(4'hA, 8'd0, 16'hB000);
    prog[2] = ins(4'hC, 8'd11, 16'hB040);
    run(td);
    chk("R5", "strobe count", nlog, 3);
    chk("R5", "gelu bit", lg_c[0], 16);
    chk("R5", "gelu func", lg_f[0], 6);
    chk("R5", "gelu imm", lg_i[0], 5);
    chk("R6", "norm time", lg_t[1], 3 + N + 2);
    chk("R6", "norm bit", lg_c[1], 32);
    chk("R5", "scale time", lg_t[2], 3 + N + 2 + 2*N + 2);
    chk("R5", "scale func", lg_f[2], 12);
    chk("R5", "scale imm", lg_i[2], 11);
    chk("R7", "scale addr", lg_a[2], 'hB040);
    chk("R5", "halt time", td, lg_t[2] + N + 2);
  endtask

  task automatic t_sync();
    int td;
    do_reset(40);
    prog[0] = ins(4'h1, 8'h0, 16'h5000);
    prog[1] = ins(4'hD, 8'h0, 16'h0);
    prog[2] = ins(4'h2, 8'h0, 16'h0);
    prog[3] = ins(4'hD, 8'h0, 16'h0);
    run(td);
    chk("R8", "strobe count", nlog, 2);
    chk("R8", "load after barrier", lg_t[1], 7 + 40);
    chk("R8", "halt after second barrier", td, lg_t[1] + 40 + 4);
  endtask

  task automatic t_loop();
    int td;
    do_reset(4);
    prog[0] = ins(4'h1, 8'h0, 16'h5000);
    prog[1] = ins(4'hE, 8'd2, 16'h0000);
    run(td);
    chk("R9", "body runs", nlog, 3);
    for (int i = 0; i < 3; i++) chk("R9", "body time", lg_t[i], 3 + i*(N + 4));
    chk("R9", "halt time", td, 3 + 2*(N + 4) + N + 4);
    do_reset(4);
    prog[0] = ins(4'hE, 8'd0, 16'h0000);
    prog[1] = ins(4'h1, 8'h0, 16'h5000);
    run(td);
    chk("R9", "zero count body runs", nlog, 1);
    chk("R9", "zero count time", lg_t[0], 5);
  endtask

  task automatic t_stall();
    int td;
    do_reset(150);
    for (int i = 0; i < 6; i++) prog[i] = ins(4'h1, 8'h0, 16'h5000);
    run(td);
    chk("R10", "strobe count", nlog, 6);
    chk("R10", "max in flight", maxinfl, DEP);
    chk("R10", "fourth issue", lg_t[3], 33);
    chk("R10", "fifth issue after first ack", lg_t[4], 5 + 150);
    chk("R10", "sixth issue after second ack", lg_t[5], 5 + 150 + N + 2);
    chk("R10", "halt time", td, 5 + 150 + 2*(N + 2));
  endtask

  initial begin
    t_reset();
    t_halt();
    t_nop();
    t_tile();
    t_act();
    t_sync();
    t_loop();
    t_stall();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      ntot++; nbad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end
endmodule